// File: doc/BRIEF.md
# Self-Refresh Entry/Exit Sequencer

This controller-side sequencer puts a DDR2-style memory device into self refresh and later wakes it up. While the device is awake the block holds the clock enable high and drives NOP on the command pins. When an entry request arrives and all banks are idle, it issues one refresh command with the clock enable driven low. It then holds the clock steady for one more cycle with DESELECT on the bus. After that it tells the clock generator that the clock may be changed or stopped.

To exit, the clock generator first reports a stable clock. An exit request is honoured once that indication has been high for two consecutive sampled cycles. The block then raises the clock enable and drives NOP. The exit hold-off has two stages. `cmd_ok` rises when the general wait of `XSNR_CYC` cycles has passed. `read_ok` rises later, when the `DLL_CYC`-cycle wait for the delay-locked loop to relock has passed. At that point the block is awake again and can accept a new entry request. Both waits are parameters counted in clock cycles, and `DLL_CYC` must be at least `XSNR_CYC`, which must be at least 1.

Top module: `sref_seq`

## Requirements
- R1: After reset: `cke`=1, command pins NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), `cmd_ok`=1, `read_ok`=1, `clk_free`=0.
- R2: An `enter_req` that is sampled high together with `banks_idle` while awake is accepted. In the next cycle the pins show REFRESH (4'b0001) with `cke`=0, and `cmd_ok` and `read_ok` fall. REFRESH lasts exactly one cycle.
- R3: An `enter_req` that is sampled while `banks_idle` is low has no effect; the outputs stay in the awake state.
- R4: The cycle after REFRESH shows `cke`=0, DESELECT (4'b1111) and `clk_free`=0. From the following cycle on, `clk_free`=1 until an exit is accepted.
- R5: While asleep, `cke` stays 0 and the pins show DESELECT.
- R6: While asleep, an `exit_req` is accepted only when `clk_stable` is sampled high in the same cycle and in the previous cycle; otherwise it is ignored.
- R7: In the cycle after an exit is accepted, `cke`=1, the pins show NOP and `clk_free`=0. NOP is held through the whole hold-off.
- R8: `cmd_ok` rises exactly `XSNR_CYC` cycles after the first cycle in which `cke` is high again.
- R9: `read_ok` rises exactly `DLL_CYC` cycles after the first cycle in which `cke` is high again. From then on the block is awake and accepts a new entry request.
- R10: An `enter_req` outside the awake state, and an `exit_req` outside the asleep state, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to enter self refresh |
| exit_req | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Clock generator reports a stable clock |
| banks_idle | input | 1 | All banks are precharged |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cmd_ok | output | 1 | Non-read commands allowed |
| read_ok | output | 1 | READ commands allowed |
| clk_free | output | 1 | Clock may be changed or stopped |

## Verification
Every output is registered. A request sampled at one rising edge therefore shows on the pins one cycle later. `cmd_ok` and `read_ok` follow `XSNR_CYC` and `DLL_CYC` cycles after the first cycle with `cke` high. The bench model advances on the same rising edge as the design. It compares all outputs 2 ns after that edge, so each cycle's expected value is checked in the cycle it is due. The stimulus places ignored requests in the refresh, hold, asleep and waking states. It also pulses `clk_stable` for a single cycle, which exercises the two-sample rule for exit.

// File: rtl/sref_pkg.sv
package sref_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_REF,
        ST_HOLD,
        ST_ASLEEP,
        ST_WAKE
    } sref_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_DES,
        CMD_REF
    } sref_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sref_pins_t;

    typedef struct packed {
        sref_state_e state;
        sref_cmd_e   cmd;
        logic        cke;
        logic        cmd_ok;
        logic        read_ok;
        logic        clk_free;
        logic        stab;
    } sref_regs_t;

endpackage

// File: rtl/sref_cnt.sv
module sref_cnt #(
    parameter int MAX = 201,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] MAX_W = CW'(MAX);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(1);
        else if (cnt_q < MAX_W)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R8: a restart always lands on one
    p_start_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/sref_cmd_enc.sv
module sref_cmd_enc
    import sref_pkg::*;
(
    input  sref_cmd_e  cmd,
    output sref_pins_t pins
);
    always_comb begin
        unique case (cmd)
            CMD_REF: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_DES: pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            default: pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/sref_fsm.sv
module sref_fsm
    import sref_pkg::*;
#(
    parameter int XSNR_CYC = 20,
    parameter int DLL_CYC  = 200,
    localparam int CW = $clog2(DLL_CYC + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_req,
    input  logic          exit_req,
    input  logic          clk_stable,
    input  logic          banks_idle,
    input  logic [CW-1:0] cnt,
    output logic          cnt_start,
    output sref_cmd_e     cmd,
    output logic          cke,
    output logic          cmd_ok,
    output logic          read_ok,
    output logic          clk_free
);
    localparam logic [CW-1:0] XSNR_W = CW'(XSNR_CYC);
    localparam logic [CW-1:0] DLL_W  = CW'(DLL_CYC);

    sref_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.stab  = clk_stable;
        cnt_start = 1'b0;
        unique case (r_q.state)
            ST_AWAKE: begin
                if (enter_req && banks_idle) begin
                    r_d.state   = ST_REF;
                    r_d.cmd     = CMD_REF;
                    r_d.cke     = 1'b0;
                    r_d.cmd_ok  = 1'b0;
                    r_d.read_ok = 1'b0;
                end
            end
            ST_REF: begin
                r_d.state = ST_HOLD;
                r_d.cmd   = CMD_DES;
            end
            ST_HOLD: begin
                r_d.state    = ST_ASLEEP;
                r_d.clk_free = 1'b1;
            end
            ST_ASLEEP: begin
                if (exit_req && clk_stable && r_q.stab) begin
                    r_d.state    = ST_WAKE;
                    r_d.cmd      = CMD_NOP;
                    r_d.cke      = 1'b1;
                    r_d.clk_free = 1'b0;
                    cnt_start    = 1'b1;
                end
            end
            ST_WAKE: begin
                if (cnt >= XSNR_W)
                    r_d.cmd_ok = 1'b1;
                if (cnt >= DLL_W) begin
                    r_d.read_ok = 1'b1;
                    r_d.state   = ST_AWAKE;
                end
            end
            default: r_d.state = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_AWAKE, cmd: CMD_NOP, cke: 1'b1, cmd_ok: 1'b1,
                     read_ok: 1'b1, clk_free: 1'b0, stab: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd      = r_q.cmd;
    assign cke      = r_q.cke;
    assign cmd_ok   = r_q.cmd_ok;
    assign read_ok  = r_q.read_ok;
    assign clk_free = r_q.clk_free;

    // R3: busy banks block entry
    p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_AWAKE && !banks_idle) |=> (r_q.state == ST_AWAKE));
    // R4: clock released only after the hold cycle
    p_free_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_free) |-> $past(r_q.state == ST_HOLD));
    // R6: wake needs two stable samples
    p_wake_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> ($past(clk_stable) && $past(r_q.stab)));
    // R8: the general wait has not ended when cke rises
    p_cmd_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cmd_ok);
endmodule

// File: rtl/sref_seq.sv
module sref_seq #(
    parameter int XSNR_CYC = 20,
    parameter int DLL_CYC  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exit_req,
    input  logic clk_stable,
    input  logic banks_idle,
    output logic cke,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cmd_ok,
    output logic read_ok,
    output logic clk_free
);
    import sref_pkg::*;

    localparam int CNT_MAX = DLL_CYC + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic          cnt_start;
    logic [CW-1:0] cnt;
    sref_cmd_e     cmd;
    sref_pins_t    pins;

    sref_cnt #(.MAX(CNT_MAX)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cnt_start),
        .cnt   (cnt)
    );

    sref_fsm #(.XSNR_CYC(XSNR_CYC), .DLL_CYC(DLL_CYC)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .clk_stable (clk_stable),
        .banks_idle (banks_idle),
        .cnt        (cnt),
        .cnt_start  (cnt_start),
        .cmd        (cmd),
        .cke        (cke),
        .cmd_ok     (cmd_ok),
        .read_ok    (read_ok),
        .clk_free   (clk_free)
    );

    sref_cmd_enc enc_i (
        .cmd  (cmd),
        .pins (pins)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;

    logic is_ref;
    assign is_ref = !cs_n && !ras_n && !cas_n && we_n;

    // R2: refresh only with cke low, for one cycle
    p_ref_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> !cke);
    p_ref_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |=> !is_ref);
    // R5: asleep means deselected
    p_sleep_des_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !is_ref) |-> cs_n);
    // R9: read permission implies command permission
    p_read_implies_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok |-> cmd_ok);
    // R4: clock released only while cke is low
    p_free_cke_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_free |-> !cke);
endmodule

// File: tb/sref_seq_tb.sv
`timescale 1ns/1ps
module sref_seq_tb_top;
    localparam int XSNR = 20;
    localparam int DLL  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 1'b0, exit_req = 1'b0, clk_stable = 1'b0, banks_idle = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, cmd_ok, read_ok, clk_free;

    always #5 clk = ~clk;

    sref_seq #(.XSNR_CYC(XSNR), .DLL_CYC(DLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .clk_stable(clk_stable), .banks_idle(banks_idle), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cmd_ok(cmd_ok), .read_ok(read_ok), .clk_free(clk_free)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural model: phase 0 awake, 1 refresh, 2 hold, 3 asleep, 4 waking
    int    m_phase = 0;
    int    m_since = 0;
    bit    m_stab  = 0;
    bit    m_slept = 0;
    string m_tag   = "R1";
    bit       e_cke, e_cmd_ok, e_read_ok, e_free;
    bit [3:0] e_pins;

    task automatic model_reset();
        m_phase = 0; m_since = 0; m_stab = 0; m_slept = 0; m_tag = "R1";
        e_cke = 1; e_pins = 4'b0111; e_cmd_ok = 1; e_read_ok = 1; e_free = 0;
    endtask

    task automatic model_step();
        bit st_prev;
        st_prev = m_stab;
        m_stab  = clk_stable;
        case (m_phase)
            0: begin
                m_tag = m_slept ? "R9" : "R1";
                if (enter_req && !banks_idle) m_tag = "R3";
                if (enter_req && banks_idle) begin
                    m_phase = 1; m_tag = "R2"; m_slept = 1;
                    e_cke = 0; e_pins = 4'b0001; e_cmd_ok = 0; e_read_ok = 0;
                end
            end
            1: begin
                m_phase = 2; e_pins = 4'b1111;
                m_tag = exit_req ? "R10" : "R4";
            end
            2: begin
                m_phase = 3; e_free = 1;
                m_tag = exit_req ? "R10" : "R4";
            end
            3: begin
                m_tag = exit_req ? "R6" : "R5";
                if (exit_req && clk_stable && st_prev) begin
                    m_phase = 4; m_since = 1; m_tag = "R7";
                    e_cke = 1; e_pins = 4'b0111; e_free = 0;
                end
            end
            default: begin
                m_since++;
                m_tag = enter_req ? "R10" : "R8";
                if (m_since > XSNR) e_cmd_ok = 1;
                if (m_since > DLL) begin
                    e_read_ok = 1; m_phase = 0; m_tag = "R9";
                end
            end
        endcase
    endtask

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", m_tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
        #2;
        if (!finished) begin
            cmp("cke", cke, e_cke);
            cmp("pins", {cs_n, ras_n, cas_n, we_n}, e_pins);
            cmp("cmd_ok", cmd_ok, e_cmd_ok);
            cmp("read_ok", read_ok, e_read_ok);
            cmp("clk_free", clk_free, e_free);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1;                              // R1 reset state checked each cycle
        wait_cyc(4);
        // R3: entry while banks busy
        enter_req = 1; banks_idle = 0; wait_cyc(3);
        // R2: accepted entry, exit requests during refresh/hold are R10
        banks_idle = 1; wait_cyc(1);
        enter_req = 0; exit_req = 1; clk_stable = 1; wait_cyc(2);
        exit_req = 0; clk_stable = 0; wait_cyc(5);   // R4, R5
        // R6: exit without stable clock, then with one-cycle stable pulse
        exit_req = 1; wait_cyc(4);
        clk_stable = 1; wait_cyc(1);
        clk_stable = 0; wait_cyc(3);
        clk_stable = 1; wait_cyc(1);            // first stable sample, ignored
        wait_cyc(1);                            // second sample, accepted (R7)
        exit_req = 0;
        // R10: entry during waking
        enter_req = 1; wait_cyc(30);
        enter_req = 0; wait_cyc(DLL);           // R8, R9
        // second round with stable clock already present
        enter_req = 1; banks_idle = 1; wait_cyc(1);
        enter_req = 0; wait_cyc(6);
        exit_req = 1; wait_cyc(1);
        exit_req = 0; wait_cyc(DLL + 10);
        // back-to-back entry right after wake
        enter_req = 1; wait_cyc(1);
        enter_req = 0; wait_cyc(4);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule